// File: doc/BRIEF.md
# Counter-Overflow Interrupt Enable Logic

This block turns counter overflow events into a single level interrupt request. It serves one cycle counter and a parameterised number of event counters (up to 31). Each counter owns an interrupt-enable bit and a sticky overflow flag. An overflow pulse from a counter sets its flag. The interrupt is raised while any counter has both its flag and its enable bit set, and only while the global counter enable is high.

Software reaches the enable bits through two register views that read back the same value. Writing ones to the set view turns bits on. Writing ones to the clear view turns bits off. A third view reads the overflow flags, and writing ones to it clears them. Removing an interrupt therefore means clearing the flag that caused it. A privilege input qualifies every access. An access made without privilege is reported as undefined and changes nothing.

The enable bits carry no defined value after reset. Software must program them before it turns on the global enable.

Top module: `ovf_irq_enable`

## Requirements
- R1: The register port uses address 0 for the enable set view, 1 for the enable clear view and 2 for the overflow status view. Address 3 reads zero and ignores writes. Read data appears on regRdata on the clock edge that captures a privileged read, and it holds until the next privileged read.
- R2: Writing 1 to a bit of the set view enables that counter's interrupt. Writing 0 to a bit of the set view leaves that bit unchanged.
- R3: Writing 1 to a bit of the clear view disables that counter's interrupt. Writing 0 to a bit of the clear view leaves that bit unchanged.
- R4: Reading the set view and reading the clear view both return the current enable bits, with 1 meaning enabled.
- R5: Bit 31 belongs to the cycle counter and bits 0 to NUM_EVT-1 belong to the event counters. All other bits read as zero in every view and ignore writes.
- R6: A one-cycle pulse on cycOvf or on evtOvf[i] sets overflow flag 31 or flag i. Writing 1 to a bit of the status view clears that flag. When a pulse and a clear hit the same bit in the same cycle, the flag ends up set.
- R7: irq is registered. After each clock edge it equals globalEn AND (the OR over all bits of flag AND enable), taken as they stood just before that edge.
- R8: While globalEn is 0, irq is 0 one edge later, whatever the flags and enable bits hold.
- R9: Clearing the only active flag lowers irq on the second clock edge after the write is presented. irq is still 1 right after the first edge.
- R10: An access with regPriv low sets regUndef to 1 for the cycle after the capturing edge. It changes no enable bit, no flag and no regRdata. A privileged access leaves regUndef at 0.
- R11: After reset the overflow flags are 0, and irq, regUndef and regRdata are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regPriv | input | 1 | Access is made in privileged mode |
| regAddr | input | 2 | View select: 0 set, 1 clear, 2 status |
| regWdata | input | 32 | Write data, one bit per counter |
| regRdata | output | 32 | Registered read data |
| regUndef | output | 1 | Previous access was unprivileged |
| cycOvf | input | 1 | Cycle counter overflow pulse |
| evtOvf | input | NUM_EVT | Event counter overflow pulses |
| globalEn | input | 1 | Global counter enable |
| irq | output | 1 | Level overflow interrupt request |

## Verification
The enable views are driven with writes whose zero bits and one bits must be told apart. A write of zeros to either view must change nothing. An all-ones write must leave the unimplemented bits at zero. Interleaved reads of both views show that they share one state. Overflow patterns are chosen to separate the two gates on the interrupt: a flag on an enabled counter with globalEn low, a flag on a disabled counter with globalEn high, and the cycle counter bit receiving a pulse and a clear in the same cycle. The irq edge is sampled one cycle after each clear, which separates the registered output from a combinational one. Unprivileged writes and reads are followed by readback, which shows that no state moved.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 2;
  localparam int CYC_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    VIEW_EN_SET = 2'd0,
    VIEW_EN_CLR = 2'd1,
    VIEW_OVF    = 2'd2,
    VIEW_NONE   = 2'd3
  } viewSel_e;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_EN   = 2'd1,
    RD_OVF  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   enSet;
    logic   enClr;
    logic   ovfClr;
    logic   rdLoad;
    rdSrc_e rdSrc;
    logic   undef;
  } ctrlStrobes_t;

  function automatic logic [REG_W-1:0] implMask(int numEvt);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i == CYC_BIT || i < numEvt) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl
  import ovf_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic              regPriv,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes,
  output logic              regUndef
);
  viewSel_e view;
  logic     undefQ;

  assign view = viewSel_e'(regAddr);

  always_comb begin
    strobes       = '0;
    strobes.rdSrc = RD_ZERO;
    if (regValid) begin
      if (!regPriv) begin
        strobes.undef = 1'b1;
      end else if (regWrite) begin
        unique case (view)
          VIEW_EN_SET: strobes.enSet  = 1'b1;
          VIEW_EN_CLR: strobes.enClr  = 1'b1;
          VIEW_OVF:    strobes.ovfClr = 1'b1;
          default:     ;
        endcase
      end else begin
        strobes.rdLoad = 1'b1;
        unique case (view)
          VIEW_EN_SET, VIEW_EN_CLR: strobes.rdSrc = RD_EN;
          VIEW_OVF:                 strobes.rdSrc = RD_OVF;
          default:                  strobes.rdSrc = RD_ZERO;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) undefQ <= 1'b0;
    else       undefQ <= strobes.undef;
  end

  assign regUndef = undefQ;
endmodule

// File: rtl/ovf_irq_datapath.sv
module ovf_irq_datapath
  import ovf_irq_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [REG_W-1:0]   regWdata,
  input  logic               cycOvf,
  input  logic [NUM_EVT-1:0] evtOvf,
  input  logic               globalEn,
  output logic [REG_W-1:0]   enBits,
  output logic [REG_W-1:0]   ovfFlags,
  output logic [REG_W-1:0]   regRdata,
  output logic               irq
);
  logic [REG_W-1:0] rdataQ;
  logic             irqQ;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b == CYC_BIT || b < NUM_EVT) begin : g_impl
      logic pulse;
      logic enQ;
      logic ovfQ;

      if (b == CYC_BIT) begin : g_cyc
        assign pulse = cycOvf;
      end else begin : g_evt
        assign pulse = evtOvf[b];
      end

      // Enable bit: deliberately without reset
      always_ff @(posedge clk) begin
        if (strobes.enSet && regWdata[b])      enQ <= 1'b1;
        else if (strobes.enClr && regWdata[b]) enQ <= 1'b0;
      end

      // Overflow flag: a pulse beats a same-cycle clear
      always_ff @(posedge clk) begin
        if (!rstN)                              ovfQ <= 1'b0;
        else if (pulse)                         ovfQ <= 1'b1;
        else if (strobes.ovfClr && regWdata[b]) ovfQ <= 1'b0;
      end

      assign enBits[b]   = enQ;
      assign ovfFlags[b] = ovfQ;
    end else begin : g_absent
      assign enBits[b]   = 1'b0;
      assign ovfFlags[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= globalEn && |(enBits & ovfFlags);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobes.rdLoad) begin
      unique case (strobes.rdSrc)
        RD_EN:   rdataQ <= enBits;
        RD_OVF:  rdataQ <= ovfFlags;
        default: rdataQ <= '0;
      endcase
    end
  end

  assign regRdata = rdataQ;
  assign irq      = irqQ;
endmodule

// File: rtl/ovf_irq_enable.sv
module ovf_irq_enable
  import ovf_irq_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic               regPriv,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               regUndef,
  input  logic               cycOvf,
  input  logic [NUM_EVT-1:0] evtOvf,
  input  logic               globalEn,
  output logic               irq
);
  ctrlStrobes_t     strobes;
  logic [REG_W-1:0] enBits;
  logic [REG_W-1:0] ovfFlags;

  ovf_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regPriv  (regPriv),
    .regAddr  (regAddr),
    .strobes  (strobes),
    .regUndef (regUndef)
  );

  ovf_irq_datapath #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .cycOvf   (cycOvf),
    .evtOvf   (evtOvf),
    .globalEn (globalEn),
    .enBits   (enBits),
    .ovfFlags (ovfFlags),
    .regRdata (regRdata),
    .irq      (irq)
  );
endmodule

// File: rtl/ovf_irq_checker.sv
module ovf_irq_checker
  import ovf_irq_pkg::*;
#(
  parameter int NUM_EVT = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regValid,
  input logic             regPriv,
  input logic [REG_W-1:0] regRdata,
  input logic             regUndef,
  input logic             cycOvf,
  input logic             globalEn,
  input logic [REG_W-1:0] enBits,
  input logic [REG_W-1:0] ovfFlags,
  input logic             irq
);
  localparam logic [REG_W-1:0] MASK = implMask(NUM_EVT);

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |=> !irq);

  assert_undef_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regPriv) |=> regUndef);

  assert_no_undef_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regPriv) |=> !regUndef);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regPriv) |=> $stable(regRdata));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regPriv && !cycOvf) |=> ovfFlags[CYC_BIT] == $past(ovfFlags[CYC_BIT]));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    cycOvf |=> ovfFlags[CYC_BIT]);

  assert_unimpl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata & ~MASK) == '0);

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((ovfFlags & enBits) == '0) |=> !irq);
endmodule

bind ovf_irq_enable ovf_irq_checker #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regValid (regValid),
  .regPriv  (regPriv),
  .regRdata (regRdata),
  .regUndef (regUndef),
  .cycOvf   (cycOvf),
  .globalEn (globalEn),
  .enBits   (enBits),
  .ovfFlags (ovfFlags),
  .irq      (irq)
);

// File: tb/ovf_irq_enable_test.sv
module ovf_irq_enable_test;
  localparam int NEVT = 4;
  localparam logic [1:0] A_SET = 2'd0, A_CLR = 2'd1, A_OVF = 2'd2, A_NONE = 2'd3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regValid = 1'b0, regWrite = 1'b0, regPriv = 1'b1;
  logic [1:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic            regUndef;
  logic            cycOvf = 1'b0;
  logic [NEVT-1:0] evtOvf = '0;
  logic            globalEn = 1'b0;
  logic            irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        sampledRead = 1'b0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  ovf_irq_enable #(.NUM_EVT(NEVT)) uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regPriv(regPriv), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .regUndef(regUndef), .cycOvf(cycOvf),
    .evtOvf(evtOvf), .globalEn(globalEn), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic p);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d; regPriv = p;
    tick();
    regValid = 1'b0; regWrite = 1'b0; regPriv = 1'b1; regWdata = '0;
  endtask

  // Driver: issues a privileged read and queues the expected value
  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a; regPriv = 1'b1;
    tick();
    regValid = 1'b0;
  endtask

  // Monitor: compares the registered read data one edge after capture
  always @(posedge clk) sampledRead <= rstN && regValid && !regWrite && regPriv;

  always @(negedge clk) begin
    if (sampledRead) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected read result actual=%h expected=none", regRdata);
      end else begin
        check(tagQ.pop_front(), regRdata, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R11 reset state
    check("R11 irq", {31'b0, irq}, 32'h0);
    check("R11 undef", {31'b0, regUndef}, 32'h0);
    check("R11 rdata", regRdata, 32'h0);
    rd(A_OVF, 32'h0, "R11 flags after reset");

    // Enable programming through both views
    wr(A_CLR, 32'hFFFF_FFFF, 1'b1);
    rd(A_SET, 32'h0, "R3 clear all via set view");
    rd(A_CLR, 32'h0, "R4 clear all via clear view");
    wr(A_SET, 32'h8000_0005, 1'b1);
    rd(A_SET, 32'h8000_0005, "R2 set bits");
    rd(A_CLR, 32'h8000_0005, "R4 clear view mirrors");
    wr(A_SET, 32'h0, 1'b1);
    rd(A_SET, 32'h8000_0005, "R2 zero write ignored");
    wr(A_CLR, 32'h0000_0001, 1'b1);
    rd(A_CLR, 32'h8000_0004, "R3 clear one bit");
    wr(A_CLR, 32'h0, 1'b1);
    rd(A_SET, 32'h8000_0004, "R3 zero write ignored");
    wr(A_SET, 32'hFFFF_FFFF, 1'b1);
    rd(A_SET, 32'h8000_000F, "R5 unimplemented bits zero");
    wr(A_CLR, 32'h0000_0002, 1'b1);
    rd(A_CLR, 32'h8000_000D, "R4 after clear bit1");
    wr(A_NONE, 32'hFFFF_FFFF, 1'b1);
    rd(A_NONE, 32'h0, "R1 spare address reads zero");
    rd(A_SET, 32'h8000_000D, "R1 spare write ignored");

    // Overflow with global enable low
    evtOvf[0] = 1'b1; tick(); evtOvf[0] = 1'b0;
    rd(A_OVF, 32'h0000_0001, "R6 flag set by pulse");
    tick(); tick();
    check("R8 gated by globalEn", {31'b0, irq}, 32'h0);
    globalEn = 1'b1;
    tick();
    check("R7 irq after globalEn", {31'b0, irq}, 32'h1);
    wr(A_OVF, 32'h0000_0001, 1'b1);
    check("R9 irq one edge after clear", {31'b0, irq}, 32'h1);
    tick();
    check("R9 irq removed", {31'b0, irq}, 32'h0);
    rd(A_OVF, 32'h0, "R6 flag cleared");

    // Flag on a disabled counter
    evtOvf[1] = 1'b1; tick(); evtOvf[1] = 1'b0;
    tick(); tick();
    check("R7 disabled counter no irq", {31'b0, irq}, 32'h0);
    rd(A_OVF, 32'h0000_0002, "R6 disabled flag still set");
    wr(A_OVF, 32'h0000_0002, 1'b1);

    // Unprivileged accesses
    held = regRdata;
    wr(A_CLR, 32'hFFFF_FFFF, 1'b0);
    check("R10 undef on write", {31'b0, regUndef}, 32'h1);
    regValid = 1'b1; regWrite = 1'b0; regAddr = A_SET; regPriv = 1'b0;
    tick();
    regValid = 1'b0; regPriv = 1'b1;
    check("R10 undef on read", {31'b0, regUndef}, 32'h1);
    check("R10 rdata unchanged", regRdata, held);
    rd(A_SET, 32'h8000_000D, "R10 enables unchanged");
    check("R10 no undef when privileged", {31'b0, regUndef}, 32'h0);

    // Cycle counter: pulse and clear in the same cycle
    cycOvf = 1'b1;
    wr(A_OVF, 32'h8000_0000, 1'b1);
    cycOvf = 1'b0;
    rd(A_OVF, 32'h8000_0000, "R6 set wins over clear");
    check("R7 cycle counter irq", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h8000_0000, 1'b1);
    tick();
    check("R3 disable drops irq", {31'b0, irq}, 32'h0);
    globalEn = 1'b0;
    wr(A_OVF, 32'h8000_0000, 1'b1);
    rd(A_OVF, 32'h0, "R6 cycle flag cleared");

    tick(); tick();
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 missing read results actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule